// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a clocked host to an asynchronous 128K x 8 static RAM. The host hands over one byte-wide read or write at a time through a valid/ready pair. The controller turns each request into a strobe sequence on the memory pins. The memory has an active-low select, an active-high select, an output enable, a write enable, a 17-bit address and an 8-bit data bus. At the chip level that data bus is bidirectional. The controller presents it as separate input, output and drive-enable signals so that the pad cell can join them.

Each phase length comes from a nanosecond limit of the memory's speed grade, rounded up to whole cycles of a clock-period parameter. With a 10 ns period and the 70 ns grade, the phases are:
- a 7-cycle read
- a 6-cycle write-enable pulse, framed by one address setup cycle and one address hold cycle
- a 3-cycle float gap between a read and a following write

A standby input parks the memory deselected so that it can retain its data at low power. After standby is released, the controller waits one read-cycle time before it accepts the next access.

Top module: `sram_ctl`

## Requirements
- R1: Reset leaves the memory deselected (`mem_cs_n`=1, `mem_cs`=0) with `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `rd_valid`=0. Once reset is released, `req_ready`=1 unless standby is asserted.
- R2: The two selects always move together: `mem_cs` equals the inverse of `mem_cs_n` in every cycle. They are asserted only while an access is in progress.
- R3: Write enable is held low for exactly WP_CYC cycles (6 by default) per write. During that time both selects are asserted and `mem_oe_n` stays high.
- R4: The write address appears on `mem_addr` with the selects asserted one cycle before write enable falls. It stays unchanged while write enable is low and for one cycle after write enable rises.
- R5: `mem_dq_oe` is high only while write enable is low and during the single cycle after it rises. During those cycles `mem_dq_out` carries the write data.
- R6: A read keeps `mem_oe_n` low with both selects asserted for RD_CYC cycles (7 by default). The data bus is sampled at the end of the last of those cycles. It is returned on `rd_data` while `rd_valid` is high for exactly one cycle.
- R7: When a write follows a read, `mem_dq_oe` stays low for at least TA_CYC cycles (3 by default) after `mem_oe_n` returns high.
- R8: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is low from acceptance until the access sequence has finished.
- R9: While `standby` is high, `req_ready` is low and the selects are deasserted once any access in progress has finished. After `standby` falls, `req_ready` stays low for RD_CYC cycles.
- R10: Data written at an address is read back unchanged, including at the lowest and highest addresses, and it survives a standby period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle strobe marking read data |
| rd_data | output | 8 | Read data |
| standby | input | 1 | Retention request; deselects the memory |
| mem_addr | output | 17 | Memory address pins |
| mem_cs_n | output | 1 | Active-low memory select |
| mem_cs | output | 1 | Active-high memory select |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data received from the memory |

## Verification
The bench connects a behavioural memory model to the pins. The model returns a junk byte until output enable has been low for a full read-cycle time, so a read that samples too early returns the wrong value. The model also keeps driving for the float time after a read, so an early data drive is reported as contention.

Several access patterns are used:
- Back-to-back writes to the lowest, highest and mid-range addresses, which show whether the address and data are latched correctly.
- A write straight after a read, which shows whether the turnaround gap is inserted.
- A read straight after a write, which needs no gap.
- A standby period followed by reads, which shows the wake hold-off and confirms that the stored data was retained.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_WSET,
        ST_WPUL,
        ST_WHLD,
        ST_READ,
        ST_STBY,
        ST_WAKE
    } ctl_state_e;

    typedef struct packed {
        logic cs_n;
        logic cs;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } pin_ctl_t;

    // Convert a limit in ns to whole clock cycles, rounding up.
    function automatic int ns_to_cyc(int ns, int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max_of(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // Memory strobe levels for each sequencer state.
    function automatic pin_ctl_t pins_for(ctl_state_e s);
        pin_ctl_t p;
        p.cs_n  = 1'b1;
        p.cs    = 1'b0;
        p.oe_n  = 1'b1;
        p.we_n  = 1'b1;
        p.dq_oe = 1'b0;
        case (s)
            ST_WSET: begin
                p.cs_n = 1'b0;
                p.cs   = 1'b1;
            end
            ST_WPUL: begin
                p.cs_n  = 1'b0;
                p.cs    = 1'b1;
                p.we_n  = 1'b0;
                p.dq_oe = 1'b1;
            end
            ST_WHLD: begin
                p.cs_n  = 1'b0;
                p.cs    = 1'b1;
                p.dq_oe = 1'b1;
            end
            ST_READ: begin
                p.cs_n = 1'b0;
                p.cs   = 1'b1;
                p.oe_n = 1'b0;
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int RD_CYC = 7,
    parameter int WP_CYC = 6,
    parameter int TA_CYC = 3,
    parameter int CNT_W  = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       standby,
    output logic       req_ready,
    output logic       accept,
    output logic       rd_done,
    output ctl_state_e state_n
);

    ctl_state_e       state;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             last_rd, last_rd_n;

    assign req_ready = (state == ST_IDLE) && !standby;

    always_comb begin
        state_n   = state;
        cnt_n     = cnt;
        last_rd_n = last_rd;
        accept    = 1'b0;
        rd_done   = 1'b0;
        case (state)
            ST_IDLE: begin
                cnt_n = '0;
                if (standby) begin
                    state_n = ST_STBY;
                end else if (req_valid) begin
                    accept = 1'b1;
                    if (req_write) state_n = last_rd ? ST_TURN : ST_WSET;
                    else           state_n = ST_READ;
                end
            end
            ST_TURN: begin
                if (cnt == CNT_W'(TA_CYC - 1)) begin
                    state_n = ST_WSET;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            ST_WSET: begin
                state_n   = ST_WPUL;
                cnt_n     = '0;
                last_rd_n = 1'b0;
            end
            ST_WPUL: begin
                if (cnt == CNT_W'(WP_CYC - 1)) begin
                    state_n = ST_WHLD;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            ST_WHLD: state_n = ST_IDLE;
            ST_READ: begin
                if (cnt == CNT_W'(RD_CYC - 1)) begin
                    rd_done   = 1'b1;
                    last_rd_n = 1'b1;
                    state_n   = ST_IDLE;
                    cnt_n     = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            ST_STBY: begin
                cnt_n = '0;
                if (!standby) state_n = ST_WAKE;
            end
            ST_WAKE: begin
                if (cnt == CNT_W'(RD_CYC - 1)) begin
                    state_n = ST_IDLE;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            last_rd <= 1'b0;
        end else begin
            state   <= state_n;
            cnt     <= cnt_n;
            last_rd <= last_rd_n;
        end
    end

endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_state_e        state_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output pin_ctl_t          ctl_q
);

    // Strobes are registered from the next state, so the pins are
    // glitch-free and line up with the sequencer's current state.
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= pins_for(ST_IDLE);
        end else begin
            ctl_q <= pins_for(state_n);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

endmodule

// File: rtl/sram_ctl_rcap.sv
module sram_ctl_rcap #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_done;
            if (rd_done) rd_data <= mem_dq_in;
        end
    end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 8,
    parameter int CLK_NS  = 10,
    parameter int T_RC_NS = 70,
    parameter int T_WP_NS = 55,
    parameter int T_CW_NS = 65,
    parameter int T_DW_NS = 30,
    parameter int T_HZ_NS = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              standby,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int RD_CYC = ns_to_cyc(T_RC_NS, CLK_NS);
    // Pulse must meet its own minimum, the data-valid window, the
    // select-to-end time (setup cycle counts) and the full cycle time.
    localparam int WP_CYC = max_of(max_of(ns_to_cyc(T_WP_NS, CLK_NS),
                                          ns_to_cyc(T_DW_NS, CLK_NS)),
                                   max_of(ns_to_cyc(T_CW_NS, CLK_NS) - 1,
                                          RD_CYC - 2));
    localparam int TA_CYC = max_of(ns_to_cyc(T_HZ_NS, CLK_NS), 1);
    localparam int CNT_W  = $clog2(max_of(max_of(RD_CYC, WP_CYC), TA_CYC) + 1);

    ctl_state_e state_n;
    logic       accept;
    logic       rd_done;
    pin_ctl_t   ctl_q;

    sram_ctl_seq #(
        .RD_CYC(RD_CYC),
        .WP_CYC(WP_CYC),
        .TA_CYC(TA_CYC),
        .CNT_W (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_write(req_write),
        .standby  (standby),
        .req_ready(req_ready),
        .accept   (accept),
        .rd_done  (rd_done),
        .state_n  (state_n)
    );

    sram_ctl_pins #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_pins (
        .clk       (clk),
        .rst       (rst),
        .state_n   (state_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_addr  (mem_addr),
        .mem_dq_out(mem_dq_out),
        .ctl_q     (ctl_q)
    );

    sram_ctl_rcap #(
        .DATA_W(DATA_W)
    ) u_rcap (
        .clk      (clk),
        .rst      (rst),
        .rd_done  (rd_done),
        .mem_dq_in(mem_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign mem_cs_n  = ctl_q.cs_n;
    assign mem_cs    = ctl_q.cs;
    assign mem_oe_n  = ctl_q.oe_n;
    assign mem_we_n  = ctl_q.we_n;
    assign mem_dq_oe = ctl_q.dq_oe;

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int ADDR_W = 17,
    parameter int TA_CYC = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              standby,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_cs,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);

    // Cycles since output enable was last low, saturating.
    logic [7:0] since_rd;
    always_ff @(posedge clk) begin
        if (rst)              since_rd <= 8'hFF;
        else if (!mem_oe_n)   since_rd <= 8'h00;
        else if (since_rd != 8'hFF) since_rd <= since_rd + 8'h01;
    end

    // R2
    sel_pair_chk: assert property (@(posedge clk) disable iff (rst)
        mem_cs == !mem_cs_n);

    // R3
    we_frame_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (mem_oe_n && !mem_cs_n && mem_cs));

    // R4
    addr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> $stable(mem_addr));

    // R4
    addr_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> $past(!mem_cs_n));

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> ($stable(mem_addr) && !mem_cs_n));

    // R5
    drive_win_chk: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!mem_we_n || $past(!mem_we_n)));

    // R6
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R7
    turn_gap_chk: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (since_rd >= 8'(TA_CYC)));

    // R8
    idle_desel_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_cs_n && mem_we_n));

    // R9
    stby_block_chk: assert property (@(posedge clk) disable iff (rst)
        standby |-> !req_ready);

endmodule

bind sram_ctl sram_ctl_chk #(
    .ADDR_W(ADDR_W),
    .TA_CYC(TA_CYC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .standby  (standby),
    .req_ready(req_ready),
    .rd_valid (rd_valid),
    .mem_addr (mem_addr),
    .mem_cs_n (mem_cs_n),
    .mem_cs   (mem_cs),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_sram_ctl.sv
module sim_sram_ctl;

    localparam int RD_CYC = (70 + 9) / 10;
    localparam int WP_CYC = (55 + 9) / 10;
    localparam int TA_CYC = (25 + 9) / 10;
    localparam int NVEC   = 10;

    // {write, addr[16:0], data[7:0]}
    localparam logic [25:0] VEC [NVEC] = '{
        {1'b1, 17'h00001, 8'h5A},
        {1'b1, 17'h1FFFF, 8'hC3},
        {1'b1, 17'h00000, 8'h01},
        {1'b0, 17'h00001, 8'h00},
        {1'b0, 17'h1FFFF, 8'h00},
        {1'b1, 17'h00001, 8'hA5},
        {1'b0, 17'h00001, 8'h00},
        {1'b0, 17'h00000, 8'h00},
        {1'b1, 17'h10000, 8'h7E},
        {1'b0, 17'h10000, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        standby = 1'b0;
    logic        req_ready, rd_valid, mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  rd_data, mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;
    logic [16:0] mem_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    sram_ctl u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .standby(standby),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural memory model, evaluated mid-cycle.
    logic [7:0]  mem    [int];
    logic [7:0]  shadow [int];
    int          rd_cnt = 0, w_cnt = 0, flt = 0;
    logic [16:0] w_addr, prev_addr = '0;
    logic [7:0]  w_data;
    bit          prev_sel = 0;

    always @(negedge clk) begin
        if (!rst) begin
            bit sel, mdrv, wact;
            sel  = !mem_cs_n && mem_cs;
            mdrv = sel && !mem_oe_n && mem_we_n;
            wact = sel && !mem_we_n;
            if (mdrv) begin
                rd_cnt++;
                flt = TA_CYC;
                mem_dq_in = (rd_cnt >= RD_CYC && mem.exists(int'(mem_addr))) ?
                            mem[int'(mem_addr)] : 8'hEE;
            end else begin
                rd_cnt = 0;
                mem_dq_in = 8'hEE;
                if (flt > 0) begin
                    chk(!mem_dq_oe, "R7 drive during float", int'(mem_dq_oe), 0);
                    flt--;
                end
            end
            if (wact) begin
                chk(mem_oe_n, "R3 oe during write", int'(mem_oe_n), 1);
                chk(mem_dq_oe, "R5 data not driven in pulse", int'(mem_dq_oe), 1);
                if (w_cnt == 0)
                    chk(prev_sel && prev_addr == mem_addr, "R4 setup", int'(prev_addr), int'(mem_addr));
                else
                    chk(mem_addr == w_addr, "R4 addr moved", int'(mem_addr), int'(w_addr));
                w_cnt++;
                w_addr = mem_addr;
                w_data = mem_dq_out;
            end else if (w_cnt != 0) begin
                chk(w_cnt == WP_CYC, "R3 pulse length", w_cnt, WP_CYC);
                chk(sel && mem_addr == w_addr, "R4 hold", int'(mem_addr), int'(w_addr));
                chk(mem_dq_oe && mem_dq_out == w_data, "R5 hold data", int'(mem_dq_out), int'(w_data));
                mem[int'(w_addr)] = w_data;
                w_cnt = 0;
            end else if (mem_dq_oe) begin
                chk(0, "R5 stray drive", 1, 0);
            end
            prev_sel  = sel;
            prev_addr = mem_addr;
        end
    end

    task automatic report_end();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic do_op(input bit wr, input logic [16:0] a, input logic [7:0] d);
        int guard;
        guard = 0;
        while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
        chk(!req_ready, "R8 ready during access", int'(req_ready), 0);
        if (wr) begin
            shadow[int'(a)] = d;
            guard = 0;
            while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
        end else begin
            int lat;
            lat = 1;
            while (!rd_valid && lat < 100) begin @(negedge clk); lat++; end
            chk(lat == RD_CYC + 1, "R6 read latency", lat, RD_CYC + 1);
            chk(rd_data == shadow[int'(a)], "R10 read data", int'(rd_data), int'(shadow[int'(a)]));
            @(negedge clk);
            chk(!rd_valid, "R6 strobe width", int'(rd_valid), 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog", 0, 1);
            report_end();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(mem_cs_n && !mem_cs, "R1 selects", {mem_cs_n, mem_cs}, 2'b10);
        chk(mem_oe_n && mem_we_n, "R1 strobes", {mem_oe_n, mem_we_n}, 2'b11);
        chk(!mem_dq_oe && !rd_valid, "R1 drive/valid", {mem_dq_oe, rd_valid}, 0);
        chk(req_ready, "R1 ready", int'(req_ready), 1);

        for (int i = 0; i < NVEC; i++)
            do_op(VEC[i][25], VEC[i][24:8], VEC[i][7:0]);

        // R2 selects inactive while idle
        chk(mem_cs_n && !mem_cs, "R2 idle deselect", {mem_cs_n, mem_cs}, 2'b10);

        // Read immediately followed by write at the same address (R7)
        do_op(1'b0, 17'h1FFFF, 8'h00);
        do_op(1'b1, 17'h1FFFF, 8'h3C);
        do_op(1'b0, 17'h1FFFF, 8'h00);

        // R9 standby and wake hold-off
        standby = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            chk(mem_cs_n && !mem_cs && !req_ready, "R9 standby deselect",
                {mem_cs_n, mem_cs, req_ready}, 3'b100);
            @(negedge clk);
        end
        standby = 1'b0;
        begin
            int low;
            low = 0;
            @(negedge clk);
            while (!req_ready && low < 50) begin low++; @(negedge clk); end
            chk(low == RD_CYC, "R9 wake hold-off", low, RD_CYC);
        end
        // R10 retention after standby
        do_op(1'b0, 17'h00000, 8'h00);
        do_op(1'b0, 17'h00001, 8'h00);

        repeat (4) @(negedge clk);
        done = 1;
        report_end();
    end

endmodule